// File: doc/BRIEF.md
# Aliased Control and Status Register Bank for a Serial Port

This block is the software-facing register bank of a serial peripheral. A simple strobed bus (word address, write data, write strobe, read strobe) reaches a main control word, a second control word that carries the fault-interrupt enables, a 9-bit clock divisor, and a status word whose error flags are raised by the serial engine. The control words and the status word each sit in a group of four consecutive word addresses. The first address of a group reads and writes the register directly. The other three apply a bitwise clear, set or toggle with the write data as the mask, so a driver can change one field without a read-modify-write.

A single data-port word passes writes straight to the transmit queue as a push strobe. Reads from it pop the receive queue. The queues, the shifter and the clock generator are outside the block. The bank exports the stored control values, a flush level taken from the enable bit, and one fault interrupt.

Top module: `serial_regbank`

## Requirements
- R1: Reset clears both control words, the divisor and all status flags, so every register reads zero apart from live status bit 5. `engine_flush` is high and `fault_irq` is low after reset.
- R2: A plain write to word 0x00 (main control) or 0x40 (second control) stores all 32 bits, and a read of that word returns them.
- R3: A write to group base + 0x4 clears every bit of the register where the write data holds a 1. All other bits keep their value.
- R4: A write to group base + 0x8 sets every bit of the register where the write data holds a 1.
- R5: A write to group base + 0xC inverts every bit of the register where the write data holds a 1. A read at +0x4, +0x8 or +0xC returns the stored register value.
- R6: The divisor sits only at word 0x30. It stores write-data bits 8:0, and a read returns bits 31:9 as zero.
- R7: Status word 0x10 holds three flags: overflow at bit 6, underrun at bit 8 and frame error at bit 12. A one-cycle pulse on the matching event input sets the flag from the next cycle on. The flag then stays set until a write to 0x14 has a 1 at that bit position. If an event and a clear come in the same cycle, the flag ends up set. Writes to 0x10, 0x18 and 0x1C leave the flags unchanged. Bit 5 reads the live `rxq_empty` input.
- R8: `fault_irq` is high exactly when some flag is set and its enable bit in the second control word is set. The enables are bit 10 for underrun, bit 11 for overflow and bit 12 for frame error.
- R9: `engine_flush` is high whenever main-control bit 15 (enable) is zero.
- R10: A write to word 0x20 raises `txq_push` for that cycle, with `txq_wdata` equal to the write data. A read of 0x20 with `rxq_empty` low raises `rxq_pop` and returns `rxq_rdata`. With `rxq_empty` high, the read returns zero and raises no pop.
- R11: Words 0x24–0x2C, 0x34–0x3C and every word from 0x50 up read zero. A write to any of them changes no register and raises no push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| txq_push | output | 1 | Push into the transmit queue |
| txq_wdata | output | 32 | Data pushed into the transmit queue |
| rxq_pop | output | 1 | Pop from the receive queue |
| rxq_rdata | input | 32 | Head of the receive queue |
| rxq_empty | input | 1 | Receive queue empty |
| evt_overflow | input | 1 | Receive overflow event pulse |
| evt_underrun | input | 1 | Transmit underrun event pulse |
| evt_frame_err | input | 1 | Frame error event pulse |
| ctrl_q | output | 32 | Stored main control word |
| ctrl2_q | output | 32 | Stored second control word |
| baud_q | output | 9 | Stored clock divisor |
| engine_flush | output | 1 | High while the peripheral is disabled |
| fault_irq | output | 1 | Fault interrupt |

## Verification
The hardest case to reach is an engine event that arrives in the same cycle as a software clear of the same flag. A single interrupt enable can also mask one sticky flag while another flag stays set. The stimulus drives `evt_overflow` during the very cycle that the clear-alias write is on the bus, then reads the status back. It raises underrun and frame error while only the overflow enable is on, and then switches the enables through the set alias. This shows whether `fault_irq` follows the flag-enable pairing or only the flags.

// File: rtl/serial_regbank_pkg.sv
package serial_regbank_pkg;

    localparam int DATA_W  = 32;
    localparam int BAUD_W  = 9;

    localparam int BIT_RXEMPTY = 5;
    localparam int BIT_OVF     = 6;
    localparam int BIT_UR      = 8;
    localparam int BIT_FRM     = 12;
    localparam int BIT_ENABLE  = 15;
    localparam int IE_UR       = 10;
    localparam int IE_OVF      = 11;
    localparam int IE_FRM      = 12;

    typedef enum logic [1:0] {
        ALIAS_PLAIN = 2'd0,
        ALIAS_CLR   = 2'd1,
        ALIAS_SET   = 2'd2,
        ALIAS_INV   = 2'd3
    } alias_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_STAT,
        SEL_DATA,
        SEL_BAUD,
        SEL_CTRL2
    } sel_e;

    typedef struct packed {
        logic ovf;
        logic ur;
        logic frm;
    } flags_t;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] ctrl2;
        logic [BAUD_W-1:0] baud;
        flags_t            flags;
    } bank_t;

endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
    import serial_regbank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel,
    output alias_e            als
);
    localparam int GRP_W = ADDR_W - 4;

    logic [GRP_W-1:0] grp;

    always_comb begin
        grp = addr[ADDR_W-1:4];
        als = alias_e'(addr[3:2]);
        sel = SEL_NONE;
        if (addr[1:0] == 2'b00) begin
            if (grp == GRP_W'(0))
                sel = SEL_CTRL;
            else if (grp == GRP_W'(1))
                sel = SEL_STAT;
            else if (grp == GRP_W'(2) && als == ALIAS_PLAIN)
                sel = SEL_DATA;
            else if (grp == GRP_W'(3) && als == ALIAS_PLAIN)
                sel = SEL_BAUD;
            else if (grp == GRP_W'(4))
                sel = SEL_CTRL2;
        end
    end
endmodule

// File: rtl/regbank_alias.sv
module regbank_alias
    import serial_regbank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] wdata,
    input  alias_e       op,
    input  logic         hit,
    output logic [W-1:0] nxt
);
    always_comb begin
        nxt = cur;
        if (hit) begin
            unique case (op)
                ALIAS_PLAIN: nxt = wdata;
                ALIAS_CLR:   nxt = cur & ~wdata;
                ALIAS_SET:   nxt = cur | wdata;
                ALIAS_INV:   nxt = cur ^ wdata;
            endcase
        end
    end
endmodule

// File: rtl/serial_regbank.sv
module serial_regbank
    import serial_regbank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_wr,
    input  logic                bus_rd,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                txq_push,
    output logic [DATA_W-1:0]   txq_wdata,
    output logic                rxq_pop,
    input  logic [DATA_W-1:0]   rxq_rdata,
    input  logic                rxq_empty,
    input  logic                evt_overflow,
    input  logic                evt_underrun,
    input  logic                evt_frame_err,
    output logic [DATA_W-1:0]   ctrl_q,
    output logic [DATA_W-1:0]   ctrl2_q,
    output logic [BAUD_W-1:0]   baud_q,
    output logic                engine_flush,
    output logic                fault_irq
);
    sel_e   sel;
    alias_e als;
    bank_t  s_d, s_q;

    logic [DATA_W-1:0] ctrl_nxt, ctrl2_nxt;
    logic [BAUD_W-1:0] baud_nxt;
    logic              ovf_flag;

    regbank_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel),
        .als  (als)
    );

    regbank_alias #(.W(DATA_W)) u_ctrl (
        .cur   (s_q.ctrl),
        .wdata (bus_wdata),
        .op    (als),
        .hit   (bus_wr && sel == SEL_CTRL),
        .nxt   (ctrl_nxt)
    );

    regbank_alias #(.W(DATA_W)) u_ctrl2 (
        .cur   (s_q.ctrl2),
        .wdata (bus_wdata),
        .op    (als),
        .hit   (bus_wr && sel == SEL_CTRL2),
        .nxt   (ctrl2_nxt)
    );

    regbank_alias #(.W(BAUD_W)) u_baud (
        .cur   (s_q.baud),
        .wdata (bus_wdata[BAUD_W-1:0]),
        .op    (als),
        .hit   (bus_wr && sel == SEL_BAUD),
        .nxt   (baud_nxt)
    );

    // Next-state computation
    always_comb begin
        flags_t clr_mask;
        s_d       = s_q;
        s_d.ctrl  = ctrl_nxt;
        s_d.ctrl2 = ctrl2_nxt;
        s_d.baud  = baud_nxt;
        clr_mask  = '0;
        if (bus_wr && sel == SEL_STAT && als == ALIAS_CLR) begin
            clr_mask.ovf = bus_wdata[BIT_OVF];
            clr_mask.ur  = bus_wdata[BIT_UR];
            clr_mask.frm = bus_wdata[BIT_FRM];
        end
        // engine events take priority over a simultaneous clear
        s_d.flags.ovf = (s_q.flags.ovf & ~clr_mask.ovf) | evt_overflow;
        s_d.flags.ur  = (s_q.flags.ur  & ~clr_mask.ur)  | evt_underrun;
        s_d.flags.frm = (s_q.flags.frm & ~clr_mask.frm) | evt_frame_err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    // Read mux and queue strobes
    always_comb begin
        bus_rdata = '0;
        rxq_pop   = 1'b0;
        if (bus_rd) begin
            unique case (sel)
                SEL_CTRL:  bus_rdata = s_q.ctrl;
                SEL_CTRL2: bus_rdata = s_q.ctrl2;
                SEL_BAUD:  bus_rdata = {{(DATA_W-BAUD_W){1'b0}}, s_q.baud};
                SEL_STAT: begin
                    bus_rdata[BIT_RXEMPTY] = rxq_empty;
                    bus_rdata[BIT_OVF]     = s_q.flags.ovf;
                    bus_rdata[BIT_UR]      = s_q.flags.ur;
                    bus_rdata[BIT_FRM]     = s_q.flags.frm;
                end
                SEL_DATA: begin
                    if (!rxq_empty) begin
                        bus_rdata = rxq_rdata;
                        rxq_pop   = 1'b1;
                    end
                end
                default: bus_rdata = '0;
            endcase
        end
    end

    assign txq_push     = bus_wr && sel == SEL_DATA;
    assign txq_wdata    = bus_wdata;
    assign ctrl_q       = s_q.ctrl;
    assign ctrl2_q      = s_q.ctrl2;
    assign baud_q       = s_q.baud;
    assign engine_flush = ~s_q.ctrl[BIT_ENABLE];
    assign fault_irq    = (s_q.flags.ur  & s_q.ctrl2[IE_UR])
                        | (s_q.flags.ovf & s_q.ctrl2[IE_OVF])
                        | (s_q.flags.frm & s_q.ctrl2[IE_FRM]);
    assign ovf_flag     = s_q.flags.ovf;

endmodule

// File: rtl/serial_regbank_chk.sv
module serial_regbank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [31:0] bus_rdata,
    input logic        txq_push,
    input logic        rxq_pop,
    input logic        rxq_empty,
    input logic        evt_overflow,
    input logic        ovf_flag
);
    logic rsv;
    assign rsv = (bus_addr[7:4] == 4'h2 && bus_addr[3:2] != 2'b00)
              || (bus_addr[7:4] == 4'h3 && bus_addr[3:2] != 2'b00)
              || (bus_addr[7:4] > 4'h4);

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !(bus_wr && bus_addr == 8'h14 && bus_wdata[6])) |=> ovf_flag);

    assert_ovf_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_overflow |=> ovf_flag);

    assert_baud_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 8'h30) |-> bus_rdata[31:9] == 23'd0);

    assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && rsv) |-> bus_rdata == 32'd0);

    assert_empty_no_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 8'h20 && rxq_empty) |-> (!rxq_pop && bus_rdata == 32'd0));

    assert_push_only_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        txq_push |-> (bus_wr && bus_addr == 8'h20));

    assert_push_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h20) |-> txq_push);
endmodule

bind serial_regbank serial_regbank_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_rdata    (bus_rdata),
    .txq_push     (txq_push),
    .rxq_pop      (rxq_pop),
    .rxq_empty    (rxq_empty),
    .evt_overflow (evt_overflow),
    .ovf_flag     (ovf_flag)
);

// File: tb/serial_regbank_test.sv
module serial_regbank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        txq_push;
    logic [31:0] txq_wdata;
    logic        rxq_pop;
    logic [31:0] rxq_rdata = '0;
    logic        rxq_empty = 1'b1;
    logic        evt_overflow = 1'b0;
    logic        evt_underrun = 1'b0;
    logic        evt_frame_err = 1'b0;
    logic [31:0] ctrl_q, ctrl2_q;
    logic [8:0]  baud_q;
    logic        engine_flush, fault_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    serial_regbank uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .txq_push(txq_push), .txq_wdata(txq_wdata), .rxq_pop(rxq_pop),
        .rxq_rdata(rxq_rdata), .rxq_empty(rxq_empty),
        .evt_overflow(evt_overflow), .evt_underrun(evt_underrun),
        .evt_frame_err(evt_frame_err), .ctrl_q(ctrl_q), .ctrl2_q(ctrl2_q),
        .baud_q(baud_q), .engine_flush(engine_flush), .fault_irq(fault_irq)
    );

    // vector: {is_write, req, addr, data/expected}
    localparam int NV = 20;
    localparam logic [44:0] VEC [NV] = '{
        {1'b1, 4'd2,  8'h00, 32'hA5A5_0F0F},  // R2 plain write ctrl
        {1'b0, 4'd2,  8'h00, 32'hA5A5_0F0F},  // R2
        {1'b1, 4'd3,  8'h04, 32'h0000_000F},  // R3 clear
        {1'b0, 4'd5,  8'h0C, 32'hA5A5_0F00},  // R5 alias read
        {1'b1, 4'd4,  8'h08, 32'hF000_0000},  // R4 set
        {1'b0, 4'd4,  8'h04, 32'hF5A5_0F00},  // R4
        {1'b1, 4'd5,  8'h0C, 32'hFFFF_0000},  // R5 invert
        {1'b0, 4'd5,  8'h00, 32'h0A5A_0F00},  // R5
        {1'b1, 4'd6,  8'h30, 32'hFFFF_FFFF},  // R6 divisor
        {1'b0, 4'd6,  8'h30, 32'h0000_01FF},  // R6
        {1'b1, 4'd2,  8'h40, 32'h1234_5678},  // R2 ctrl2
        {1'b0, 4'd5,  8'h48, 32'h1234_5678},  // R5
        {1'b1, 4'd5,  8'h4C, 32'h0000_1C00},  // R5 invert ctrl2
        {1'b0, 4'd5,  8'h40, 32'h1234_4A78},  // R5
        {1'b1, 4'd11, 8'h24, 32'hFFFF_FFFF},  // R11 reserved write
        {1'b0, 4'd11, 8'h24, 32'h0000_0000},  // R11
        {1'b1, 4'd11, 8'h34, 32'h0000_0000},  // R11 reserved write
        {1'b0, 4'd11, 8'h30, 32'h0000_01FF},  // R11 divisor untouched
        {1'b0, 4'd11, 8'h3C, 32'h0000_0000},  // R11
        {1'b0, 4'd11, 8'h58, 32'h0000_0000}   // R11
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        do_read(8'h00, r); check("R1 ctrl", r, 32'h0);
        do_read(8'h40, r); check("R1 ctrl2", r, 32'h0);
        do_read(8'h30, r); check("R1 divisor", r, 32'h0);
        do_read(8'h10, r); check("R1 status", r, 32'h20);
        check("R1 flush", {31'd0, engine_flush}, 32'd1);
        check("R1 irq", {31'd0, fault_irq}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][44]) begin
                do_write(VEC[i][39:32], VEC[i][31:0]);
            end else begin
                do_read(VEC[i][39:32], r);
                check($sformatf("R%0d vector %0d", VEC[i][43:40], i), r, VEC[i][31:0]);
            end
        end

        // R7 sticky flags and clear alias
        @(negedge clk); evt_overflow = 1'b1; @(negedge clk); evt_overflow = 1'b0;
        do_read(8'h10, r); check("R7 overflow set", r, 32'h60);
        do_write(8'h10, 32'h0);
        do_write(8'h18, 32'hFFFF);
        do_write(8'h1C, 32'hFFFF);
        do_read(8'h1C, r); check("R7 plain/set/inv ignored", r, 32'h60);
        do_write(8'h14, 32'h40);
        do_read(8'h10, r); check("R7 cleared", r, 32'h20);
        @(negedge clk); evt_underrun = 1'b1; evt_frame_err = 1'b1;
        @(negedge clk); evt_underrun = 1'b0; evt_frame_err = 1'b0;
        do_read(8'h10, r); check("R7 underrun+frame", r, 32'h1120);

        // R8 interrupt gating: ctrl2 = 0x12344A78 enables only overflow
        check("R8 masked", {31'd0, fault_irq}, 32'd0);
        do_write(8'h48, 32'h1000);
        check("R8 frame enabled", {31'd0, fault_irq}, 32'd1);
        do_write(8'h14, 32'h1100);
        check("R8 flags cleared", {31'd0, fault_irq}, 32'd0);
        @(negedge clk); evt_overflow = 1'b1; @(negedge clk); evt_overflow = 1'b0;
        check("R8 overflow enabled", {31'd0, fault_irq}, 32'd1);

        // R7 event wins over simultaneous clear
        do_write(8'h14, 32'h40);
        @(negedge clk);
        bus_addr = 8'h14; bus_wdata = 32'h40; bus_wr = 1'b1; evt_overflow = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; evt_overflow = 1'b0;
        do_read(8'h10, r); check("R7 event beats clear", r, 32'h60);
        do_write(8'h14, 32'h40);

        // R9 enable bit
        check("R9 disabled", {31'd0, engine_flush}, 32'd1);
        do_write(8'h08, 32'h8000);
        check("R9 enabled", {31'd0, engine_flush}, 32'd0);
        do_write(8'h04, 32'h8000);
        check("R9 disabled again", {31'd0, engine_flush}, 32'd1);

        // R10 data port
        @(negedge clk);
        bus_addr = 8'h20; bus_wdata = 32'hDEAD_BEEF; bus_wr = 1'b1;
        #1 check("R10 push", {31'd0, txq_push}, 32'd1);
        check("R10 push data", txq_wdata, 32'hDEAD_BEEF);
        @(negedge clk); bus_wr = 1'b0;
        #1 check("R10 push idle", {31'd0, txq_push}, 32'd0);
        @(negedge clk);
        bus_addr = 8'h00; bus_wdata = 32'h0; bus_wr = 1'b1;
        #1 check("R10 no push on ctrl", {31'd0, txq_push}, 32'd0);
        @(negedge clk); bus_wr = 1'b0;
        rxq_empty = 1'b0; rxq_rdata = 32'hCAFE_F00D;
        @(negedge clk);
        bus_addr = 8'h20; bus_rd = 1'b1;
        #1 check("R10 pop data", bus_rdata, 32'hCAFE_F00D);
        check("R10 pop", {31'd0, rxq_pop}, 32'd1);
        @(negedge clk); bus_rd = 1'b0; rxq_empty = 1'b1;
        @(negedge clk);
        bus_addr = 8'h20; bus_rd = 1'b1;
        #1 check("R10 empty data", bus_rdata, 32'h0);
        check("R10 empty no pop", {31'd0, rxq_pop}, 32'd0);
        @(negedge clk); bus_rd = 1'b0;

        // R11 reserved write raises no push
        @(negedge clk);
        bus_addr = 8'h28; bus_wdata = 32'h1; bus_wr = 1'b1;
        #1 check("R11 reserved no push", {31'd0, txq_push}, 32'd0);
        @(negedge clk); bus_wr = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule